// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the BCD time that a separate calendar counter presents and raises an alarm when that time reaches a programmed moment. It holds six alarm fields: seconds, minutes, hours, weekday, day of month and month. The month counts from 1. Each field stores a 7-bit BCD value with a compare enable above it, so software can build an alarm from any subset of fields. Examples are "every day at 07:15" or "the 12th of each month at noon". Fields that are not enabled take no part in the match.

The compare is made once per seconds tick. When at least one field is enabled and every enabled field equals the matching time field, a sticky alarm flag sets. The flag stays set until software writes it to zero. The interrupt line is the flag gated by an alarm interrupt enable. Software reaches the fields and the control byte through a byte-wide register port. The usual sequence has three steps. Software first clears the flag and the enable together. It then rewrites the fields. Finally it sets the enable again.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, every alarm field reads 0x00, the control byte reads 0x00 and `alarm_irq` is low.
- R2: A write to address 0..5 (seconds, minutes, hours, weekday, day, month in that order) stores all 8 data bits, and a read of the same address returns them. No other field changes.
- R3: Each field register holds its BCD compare value in bits 6:0 and its compare enable in bit 7. A field with bit 7 clear is left out of the match.
- R4: Writing 0x00 to a field disables it. After that, a mismatch in that field no longer blocks the alarm.
- R5: The match is evaluated only in a cycle where `sec_tick` is high. A matching time with `sec_tick` low does not set the flag.
- R6: When no field is enabled, the flag never sets.
- R7: Once set, the flag stays set after the time stops matching, until software clears it.
- R8: The control byte lives at address 6, with the flag in bit 0. A control write with bit 0 at 0 clears the flag. A write with bit 0 at 1 leaves the flag as it was and never sets it.
- R9: The control byte holds the alarm interrupt enable in bit 3, written on every control write. `alarm_irq` is high exactly when both the flag and the enable are set.
- R10: If a qualifying match and a control write that clears the flag fall in the same cycle, the flag ends up set.
- R11: A control read returns the flag in bit 0, the enable in bit 3 and zeros elsewhere. Address 7 reads 0x00, and a write to it changes nothing.
- R12: A tick on which any enabled field differs from its time field does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse marking a new second; the match is sampled here |
| time_bcd | input | 42 | Current BCD time, 7 bits per field, seconds in bits 6:0 up to month in bits 41:35 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0..5 fields, 6 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt: flag AND interrupt enable |

## Verification
The assertions assume a few things about the inputs. `sec_tick` is a clean single-cycle pulse. `time_bcd` is stable in the cycle the pulse is high. The register strobe never carries an unknown address while it is asserted. The stimulus drives every input on the falling edge and holds it across exactly one rising edge. Ticks and register writes therefore take effect at a known edge, and in the set-versus-clear case both land on the same edge. Time values stay inside legal BCD ranges, so each match result follows only from the programmed fields and is never an artefact of malformed digits.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Field geometry: a BCD value with its compare enable in the top bit.
    localparam int unsigned VALUE_BITS = 7;
    localparam int unsigned REG_BITS   = VALUE_BITS + 1;

    // Control byte bit positions, decoded by software.
    localparam int unsigned FLAG_POS = 0;
    localparam int unsigned IE_POS   = 3;

    typedef struct packed {
        logic                  cmp_on;
        logic [VALUE_BITS-1:0] bcd;
    } alarm_field_t;

    typedef struct packed {
        logic flag;
        logic irq_en;
    } ctrl_state_t;

endpackage

// File: rtl/alarm_field_bank.sv
module alarm_field_bank
    import alarm_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 6,
    parameter int unsigned ADDR_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [REG_BITS-1:0]             wdata_i,
    output alarm_field_t [NUM_FIELDS-1:0]   fields_o
);

    alarm_field_t [NUM_FIELDS-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (wr_en_i && (addr_i == ADDR_W'(i))) begin
                bank_d[i] = alarm_field_t'(wdata_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign fields_o = bank_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field_chk
        AST_ZERO_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == ADDR_W'(g) && wdata_i == '0) |=> !fields_o[g].cmp_on); // R4
        AST_UNADDRESSED_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && addr_i == ADDR_W'(g)) |=> $stable(fields_o[g])); // R2
    end

endmodule

// File: rtl/alarm_match_core.sv
module alarm_match_core
    import alarm_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 6,
    localparam int unsigned TIME_W    = NUM_FIELDS * VALUE_BITS
) (
    input  alarm_field_t [NUM_FIELDS-1:0] fields_i,
    input  logic [TIME_W-1:0]             time_bcd_i,
    output logic                          hit_o,
    output logic                          any_en_o
);

    logic [NUM_FIELDS-1:0] field_ok;
    logic [NUM_FIELDS-1:0] field_en;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        assign field_en[g] = fields_i[g].cmp_on;
        assign field_ok[g] = !fields_i[g].cmp_on
                           || (fields_i[g].bcd == time_bcd_i[g*VALUE_BITS +: VALUE_BITS]);
    end

    assign any_en_o = |field_en;
    assign hit_o    = any_en_o && (&field_ok);

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hit_i,
    input  logic ctrl_wr_i,
    input  logic flag_wbit_i,
    input  logic ie_wbit_i,
    output logic flag_o,
    output logic irq_en_o,
    output logic irq_o
);

    ctrl_state_t st_d, st_q;
    logic        sw_clear;
    logic        hw_set;

    assign sw_clear = ctrl_wr_i && !flag_wbit_i;
    assign hw_set   = tick_i && hit_i;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i) begin
            st_d.irq_en = ie_wbit_i;
        end
        if (sw_clear) begin
            st_d.flag = 1'b0;
        end
        if (hw_set) begin
            st_d.flag = 1'b1;   // set has priority over a same-cycle clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o   = st_q.flag;
    assign irq_en_o = st_q.irq_en;
    assign irq_o    = st_q.flag && st_q.irq_en;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i) |=> flag_o); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(ctrl_wr_i && !flag_wbit_i)) |=> flag_o); // R7
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i)); // R5
    AST_SW_CANNOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(tick_i && hit_i)) |=> !flag_o); // R8

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 6,
    parameter int unsigned ADDR_W     = 3,
    localparam int unsigned TIME_W    = NUM_FIELDS * VALUE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [TIME_W-1:0]   time_bcd,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_BITS-1:0] reg_wdata,
    output logic [REG_BITS-1:0] reg_rdata,
    output logic                alarm_irq
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

    alarm_field_t [NUM_FIELDS-1:0] fields;
    logic hit, any_en, flag, irq_en, ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);

    alarm_field_bank #(
        .NUM_FIELDS (NUM_FIELDS),
        .ADDR_W     (ADDR_W)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .fields_o (fields)
    );

    alarm_match_core #(
        .NUM_FIELDS (NUM_FIELDS)
    ) i_core (
        .fields_i   (fields),
        .time_bcd_i (time_bcd),
        .hit_o      (hit),
        .any_en_o   (any_en)
    );

    alarm_flag_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (sec_tick),
        .hit_i       (hit),
        .ctrl_wr_i   (ctrl_wr),
        .flag_wbit_i (reg_wdata[FLAG_POS]),
        .ie_wbit_i   (reg_wdata[IE_POS]),
        .flag_o      (flag),
        .irq_en_o    (irq_en),
        .irq_o       (alarm_irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata = fields[i];
            end
        end
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[FLAG_POS] = flag;
            reg_rdata[IE_POS]   = irq_en;
        end
    end

    AST_IDLE_BANK_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !any_en) |=> !flag); // R6
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (flag && $past(flag || (sec_tick && hit)))); // R9

endmodule

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;

    localparam int NF = 6;
    localparam int VB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic [NF*VB-1:0] time_bcd = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          alarm_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alarm_match_unit i_alarm_match_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .time_bcd  (time_bcd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .alarm_irq (alarm_irq)
    );

    function automatic logic [NF*VB-1:0] mk_time(input logic [6:0] s, m, h, w, d, mo);
        return {mo, d, w, h, m, s};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic tick(input logic [NF*VB-1:0] t, input logic pulse);
        @(negedge clk);
        time_bcd = t; sec_tick = pulse;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd6, 8'h00);
        for (int i = 0; i < NF; i++) wr(3'(i), 8'h00);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_check("R1 reset read", 3'(a), 8'h00);
        check("R1 irq at reset", {7'b0, alarm_irq}, 8'h00);
    endtask

    task automatic t_readback();
        for (int i = 0; i < NF; i++) wr(3'(i), 8'(8'h81 + 8'(i * 17)));
        for (int i = 0; i < NF; i++) rd_check("R2 field readback", 3'(i), 8'(8'h81 + 8'(i * 17)));
        wr(3'd7, 8'hFF);
        rd_check("R11 unmapped read", 3'd7, 8'h00);
        for (int i = 0; i < NF; i++) rd_check("R11 unmapped write ignored", 3'(i), 8'(8'h81 + 8'(i * 17)));
        rd_check("R11 control untouched", 3'd6, 8'h00);
        clear_all();
    endtask

    task automatic t_no_enable();
        tick(mk_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00), 1'b1);
        rd_check("R6 no field enabled", 3'd6, 8'h00);
    endtask

    task automatic t_seconds();
        wr(3'd0, 8'hB0);   // enabled, 30 s
        tick(mk_time(7'h29, 7'h10, 7'h05, 7'h02, 7'h03, 7'h04), 1'b1);
        rd_check("R12 mismatch no set", 3'd6, 8'h00);
        tick(mk_time(7'h30, 7'h10, 7'h05, 7'h02, 7'h03, 7'h04), 1'b0);
        rd_check("R5 no tick no set", 3'd6, 8'h00);
        tick(mk_time(7'h30, 7'h10, 7'h05, 7'h02, 7'h03, 7'h04), 1'b1);
        rd_check("R3 seconds-only match", 3'd6, 8'h01);
        check("R9 irq low while disabled", {7'b0, alarm_irq}, 8'h00);
        tick(mk_time(7'h31, 7'h10, 7'h05, 7'h02, 7'h03, 7'h04), 1'b1);
        rd_check("R7 flag sticky", 3'd6, 8'h01);
        wr(3'd6, 8'h01);
        rd_check("R8 write one keeps flag", 3'd6, 8'h01);
        wr(3'd6, 8'h00);
        rd_check("R8 write zero clears", 3'd6, 8'h00);
        wr(3'd6, 8'h01);
        rd_check("R8 write one does not set", 3'd6, 8'h00);
    endtask

    task automatic t_masked();
        clear_all();
        wr(3'd1, 8'h95);   // minutes 15
        wr(3'd2, 8'h87);   // hours 07
        wr(3'd6, 8'h08);
        rd_check("R11 enable readback", 3'd6, 8'h08);
        tick(mk_time(7'h42, 7'h15, 7'h07, 7'h06, 7'h28, 7'h11), 1'b1);
        rd_check("R3 minute+hour match", 3'd6, 8'h09);
        check("R9 irq flag and enable", {7'b0, alarm_irq}, 8'h01);
        wr(3'd6, 8'h00);
        check("R9 irq drops with clear", {7'b0, alarm_irq}, 8'h00);
        wr(3'd1, 8'h00);
        rd_check("R4 zero write readback", 3'd1, 8'h00);
        tick(mk_time(7'h00, 7'h59, 7'h07, 7'h06, 7'h28, 7'h11), 1'b1);
        rd_check("R4 disabled minute ignored", 3'd6, 8'h01);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_set_wins();
        // hour 07 still enabled
        @(negedge clk);
        time_bcd = mk_time(7'h00, 7'h00, 7'h07, 7'h00, 7'h01, 7'h01);
        sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h08;
        @(negedge clk);
        sec_tick = 1'b0; reg_wr = 1'b0;
        rd_check("R10 set beats clear", 3'd6, 8'h09);
        check("R10 irq raised", {7'b0, alarm_irq}, 8'h01);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_all_fields();
        wr(3'd0, 8'h80 | 8'h45);
        wr(3'd1, 8'h80 | 8'h30);
        wr(3'd2, 8'h80 | 8'h23);
        wr(3'd3, 8'h80 | 8'h05);
        wr(3'd4, 8'h80 | 8'h31);
        wr(3'd5, 8'h80 | 8'h12);
        tick(mk_time(7'h45, 7'h30, 7'h23, 7'h05, 7'h31, 7'h11), 1'b1);
        rd_check("R12 month mismatch", 3'd6, 8'h00);
        tick(mk_time(7'h45, 7'h30, 7'h23, 7'h04, 7'h31, 7'h12), 1'b1);
        rd_check("R12 weekday mismatch", 3'd6, 8'h00);
        tick(mk_time(7'h45, 7'h30, 7'h23, 7'h05, 7'h31, 7'h12), 1'b1);
        rd_check("R3 all six match", 3'd6, 8'h01);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_no_enable();
        t_seconds();
        t_masked();
        t_set_wins();
        t_all_fields();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule